// File: doc/BRIEF.md
# Channel-Gain Scan Queue Sequencer

This block holds the list of channel and gain settings that an analog acquisition front end steps through. The list has up to 256 one-byte entries. The host fills the list through a small register window. It points a queue pointer at an address, then streams bytes into a data port, and the pointer steps forward after each byte. Writing the index of the final entry arms the scan. Arming also sends the pointer back to entry 0 and starts a background check of the list's layout.

Each accepted conversion trigger does three things. It emits a one-cycle start strobe, presents the channel and gain of the current entry on registered outputs, and advances the pointer. After the entry at the armed final index, the pointer wraps to 0. The trigger comes from one of three sources, chosen by a two-bit pacer field: a host write, a synchronized external pacer pin, or a tick from an on-chip timer. A trigger that arrives while the converter reports busy is dropped and recorded in a sticky overrun flag.

A list with more than one entry must obey two layout rules. It must hold an even number of entries, and each channel's parity must match the parity of its queue address. A sticky flag reports any break of these rules. A one-entry list is exempt from both rules.

Top module: `cgq_sequencer`

## Requirements
- R1: After synchronous reset, conv_start, chan, gain, overrun and rule_err are all 0, the queue pointer is 0, the pacer field is 00 and the final index is 0.
- R2: A host write to offset 6 loads the queue pointer with the written byte. A host write to offset 7 stores the byte at the pointer and then increments the pointer. In each entry, bits [3:0] are the channel and bits [7:4] are the gain.
- R3: An accepted trigger gives conv_start high for exactly one cycle on the next clock edge. On that same edge, chan and gain take the entry at the pointer, and the pointer advances. chan and gain do not change in any other cycle.
- R4: After a conversion at the final index, the pointer returns to 0. With a final index of 0, every trigger repeats entry 0.
- R5: The pacer field is bits [1:0] of the byte written to offset 2. With codes 00 and 01, any host write to offset 0 is a trigger. With codes 10 and 11, a write to offset 0 has no effect.
- R6: With code 10, each low-to-high transition of ext_pacer gives exactly one trigger. The pin passes through two synchronizer flops, so conv_start rises on the third clock edge after the pin is first sampled high. A pin held high gives no further triggers. With other codes, the pin is ignored.
- R7: With code 11, every cycle in which timer_tick is high is a trigger. With other codes, timer_tick is ignored.
- R8: A trigger in a cycle with conv_busy high gives no strobe and does not move the pointer. It sets overrun, which then stays set until the next arm.
- R9: A host write to offset 4 arms the scan. It loads the final index from the written byte, resets the pointer to 0, and clears overrun and rule_err.
- R10: After an arm, the list is checked one entry per cycle, and the result is in place within final index + 2 cycles. If the final index is nonzero, rule_err is set when the entry count (final index + 1) is odd, or when any entry up to the final index has a channel bit 0 that differs from bit 0 of its address. A final index of 0 never sets rule_err.
- R11: If a trigger is accepted in the same cycle as a host write to offset 6 or 7, the strobe presents the entry at the pointer as it was before the write, and the host's pointer update takes effect instead of the trigger's advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_off | input | 3 | Register offset of the write |
| host_wdata | input | 8 | Write data byte |
| ext_pacer | input | 1 | Asynchronous external pacer pin |
| timer_tick | input | 1 | Pacing tick from the on-chip timer |
| conv_busy | input | 1 | Converter reports a conversion in progress |
| conv_start | output | 1 | One-cycle start-conversion strobe |
| chan | output | 4 | Channel of the entry being converted |
| gain | output | 4 | Gain code of the entry being converted |
| rule_err | output | 1 | Sticky queue layout violation |
| overrun | output | 1 | Sticky trigger-while-busy flag |

## Verification
Two functions can both act on the queue pointer in one cycle: a host write to the pointer or data port, and an accepted timer trigger that would advance the pointer. The bench raises timer_tick in the very cycle it writes offset 6. It then judges the strobe by the entry at the old pointer, and judges the next strobe by the entry at the address the host wrote. A trigger during converter busy is checked in the same way, both for the missing strobe and for the unchanged pointer on the next accepted trigger.

// File: rtl/cgq_pkg.sv
package cgq_pkg;

    localparam int ADDR_W = 8;
    localparam int CH_W   = 4;
    localparam int GAIN_W = 4;
    localparam int ENTRY_W = CH_W + GAIN_W;

    localparam logic [2:0] OFF_SWSTART = 3'd0;
    localparam logic [2:0] OFF_CTRL    = 3'd2;
    localparam logic [2:0] OFF_ARM     = 3'd4;
    localparam logic [2:0] OFF_QPTR    = 3'd6;
    localparam logic [2:0] OFF_QDATA   = 3'd7;

    typedef enum logic [1:0] {
        PACE_SW_A  = 2'b00,
        PACE_SW_B  = 2'b01,
        PACE_EXT   = 2'b10,
        PACE_TIMER = 2'b11
    } pace_sel_e;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic [CH_W-1:0]   chan;
    } cg_entry_t;

    typedef struct packed {
        logic       we;
        logic [2:0] off;
        logic [7:0] data;
    } host_wr_t;

    function automatic logic parity_matches(input cg_entry_t e, input logic [ADDR_W-1:0] idx);
        return e.chan[0] == idx[0];
    endfunction

    function automatic logic count_is_odd(input logic [ADDR_W-1:0] last_idx);
        return last_idx[0] == 1'b0;
    endfunction

endpackage

// File: rtl/cgq_trigger.sv
module cgq_trigger
    import cgq_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  pace_sel_e sel,
    input  logic      sw_start,
    input  logic      ext_pin,
    input  logic      tick,
    output logic      trig
);
    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic              ext_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], ext_pin};
            prev_q <= sync_q[SYNC_N-1];
        end
    end

    assign ext_edge = sync_q[SYNC_N-1] & ~prev_q;

    always_comb begin
        unique case (sel)
            PACE_SW_A, PACE_SW_B: trig = sw_start;
            PACE_EXT:             trig = ext_edge;
            PACE_TIMER:           trig = tick;
            default:              trig = 1'b0;
        endcase
    end
endmodule

// File: rtl/cgq_store.sv
module cgq_store
    import cgq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_ptr,
    input  logic          load_ptr,
    input  logic [AW-1:0] load_val,
    input  logic          wr_en,
    input  cg_entry_t     wr_data,
    input  logic          adv,
    input  logic [AW-1:0] last_idx,
    output logic [AW-1:0] ptr,
    output cg_entry_t     cur_entry,
    input  logic [AW-1:0] chk_idx,
    output cg_entry_t     chk_entry
);
    localparam int DEPTH = 1 << AW;

    cg_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)           ptr <= '0;
        else if (clr_ptr)  ptr <= '0;
        else if (load_ptr) ptr <= load_val;
        else if (wr_en)    ptr <= ptr + 1'b1;
        else if (adv)      ptr <= (ptr == last_idx) ? '0 : ptr + 1'b1;
    end

    assign cur_entry = mem[ptr];
    assign chk_entry = mem[chk_idx];
endmodule

// File: rtl/cgq_rulecheck.sv
module cgq_rulecheck
    import cgq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic [AW-1:0] last_idx,
    input  cg_entry_t     chk_entry,
    output logic [AW-1:0] chk_idx,
    output logic          checking,
    output logic          err
);
    logic bad_now;

    always_comb begin
        bad_now = 1'b0;
        if (last_idx != '0) begin
            bad_now = count_is_odd(last_idx) || !parity_matches(chk_entry, chk_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_idx  <= '0;
            checking <= 1'b0;
            err      <= 1'b0;
        end else if (arm) begin
            chk_idx  <= '0;
            checking <= 1'b1;
            err      <= 1'b0;
        end else if (checking) begin
            if (bad_now) err <= 1'b1;
            if (chk_idx == last_idx) checking <= 1'b0;
            else                     chk_idx  <= chk_idx + 1'b1;
        end
    end
endmodule

// File: rtl/cgq_sequencer.sv
module cgq_sequencer
    import cgq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [2:0]        host_off,
    input  logic [7:0]        host_wdata,
    input  logic              ext_pacer,
    input  logic              timer_tick,
    input  logic              conv_busy,
    output logic              conv_start,
    output logic [CH_W-1:0]   chan,
    output logic [GAIN_W-1:0] gain,
    output logic              rule_err,
    output logic              overrun
);
    host_wr_t          hw;
    pace_sel_e         sel_q;
    logic [ADDR_W-1:0] last_q;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] chk_idx;
    cg_entry_t         cur_entry;
    cg_entry_t         chk_entry;
    logic              trig, accept, arm, ptr_wr, data_wr, host_ptr_op, chk_busy;

    assign hw          = '{we: host_we, off: host_off, data: host_wdata};
    assign arm         = hw.we && hw.off == OFF_ARM;
    assign ptr_wr      = hw.we && hw.off == OFF_QPTR;
    assign data_wr     = hw.we && hw.off == OFF_QDATA;
    assign host_ptr_op = arm || ptr_wr || data_wr;
    assign accept      = trig && !conv_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= PACE_SW_A;
            last_q <= '0;
        end else begin
            if (hw.we && hw.off == OFF_CTRL) sel_q <= pace_sel_e'(hw.data[1:0]);
            if (arm) last_q <= hw.data[ADDR_W-1:0];
        end
    end

    cgq_trigger #(.SYNC_N(2)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel_q),
        .sw_start (hw.we && hw.off == OFF_SWSTART),
        .ext_pin  (ext_pacer),
        .tick     (timer_tick),
        .trig     (trig)
    );

    cgq_store #(.AW(ADDR_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr_ptr   (arm),
        .load_ptr  (ptr_wr),
        .load_val  (hw.data[ADDR_W-1:0]),
        .wr_en     (data_wr),
        .wr_data   (cg_entry_t'(hw.data)),
        .adv       (accept),
        .last_idx  (last_q),
        .ptr       (ptr),
        .cur_entry (cur_entry),
        .chk_idx   (chk_idx),
        .chk_entry (chk_entry)
    );

    cgq_rulecheck #(.AW(ADDR_W)) u_rule (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .last_idx  (last_q),
        .chk_entry (chk_entry),
        .chk_idx   (chk_idx),
        .checking  (chk_busy),
        .err       (rule_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_start <= 1'b0;
            chan       <= '0;
            gain       <= '0;
            overrun    <= 1'b0;
        end else begin
            conv_start <= accept;
            if (accept) begin
                chan <= cur_entry.chan;
                gain <= cur_entry.gain;
            end
            if (arm)                       overrun <= 1'b0;
            else if (trig && conv_busy)    overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/cgq_sequencer_chk.sv
module cgq_sequencer_chk
    import cgq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              conv_start,
    input logic              conv_busy,
    input logic              overrun,
    input logic              rule_err,
    input logic [ADDR_W-1:0] last_q,
    input logic [ADDR_W-1:0] ptr,
    input logic              accept,
    input logic              host_ptr_op,
    input logic              arm,
    input logic [CH_W-1:0]   chan,
    input logic [GAIN_W-1:0] gain
);
    // R8
    busy_blocks_start_chk: assert property (@(posedge clk) disable iff (rst)
        conv_busy |=> !conv_start);

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun && !arm) |=> overrun);

    // R4
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !host_ptr_op && ptr == last_q) |=> (ptr == '0));

    // R9
    arm_clears_chk: assert property (@(posedge clk) disable iff (rst)
        arm |=> (ptr == '0 && !overrun && !rule_err));

    // R10
    single_entry_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (last_q == '0) |-> !rule_err);

    // R3
    outputs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !conv_start |-> $stable({gain, chan}));
endmodule

bind cgq_sequencer cgq_sequencer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .conv_start  (conv_start),
    .conv_busy   (conv_busy),
    .overrun     (overrun),
    .rule_err    (rule_err),
    .last_q      (last_q),
    .ptr         (ptr),
    .accept      (accept),
    .host_ptr_op (host_ptr_op),
    .arm         (arm),
    .chan        (chan),
    .gain        (gain)
);

// File: tb/cgq_sequencer_tb.sv
module cgq_sequencer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_we = 1'b0;
    logic [2:0] host_off = '0;
    logic [7:0] host_wdata = '0;
    logic       ext_pacer = 1'b0;
    logic       timer_tick = 1'b0;
    logic       conv_busy = 1'b0;
    logic       conv_start;
    logic [3:0] chan, gain;
    logic       rule_err, overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cgq_sequencer u_dut (.*);

    // {check, offset, data, expected {gain,chan}}
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 3'd6, 8'h00, 8'h00},
        {1'b0, 3'd7, 8'h10, 8'h00},
        {1'b0, 3'd7, 8'h21, 8'h00},
        {1'b0, 3'd7, 8'h32, 8'h00},
        {1'b0, 3'd7, 8'h43, 8'h00},
        {1'b0, 3'd4, 8'h03, 8'h00},
        {1'b1, 3'd0, 8'h00, 8'h10},
        {1'b1, 3'd0, 8'h00, 8'h21},
        {1'b1, 3'd0, 8'h00, 8'h32},
        {1'b1, 3'd0, 8'h00, 8'h43},
        {1'b1, 3'd0, 8'h00, 8'h10},
        {1'b0, 3'd6, 8'h02, 8'h00},
        {1'b1, 3'd0, 8'h00, 8'h32},
        {1'b1, 3'd0, 8'h00, 8'h43}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] off, input logic [7:0] data);
        @(negedge clk);
        host_we = 1'b1; host_off = off; host_wdata = data;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic tick1();
        @(negedge clk);
        timer_tick = 1'b1;
        @(negedge clk);
        timer_tick = 1'b0;
    endtask

    task automatic count_starts(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (conv_start) cnt++;
        end
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {conv_start, chan, gain, rule_err, overrun}, 0);

        // R2 R3 R4 R5 table: load, arm, software triggers, wrap, pointer reload
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][18:16], VEC[i][15:8]);
            if (VEC[i][19]) begin
                chk("R3 strobe", conv_start, 1);
                chk("R2 R4 entry", {gain, chan}, VEC[i][7:0]);
                @(negedge clk);
                chk("R3 one cycle", conv_start, 0);
            end
        end
        repeat (6) @(negedge clk);
        chk("R10 good list", rule_err, 0);
        // pointer now wrapped to 0; move it to 1
        wr(3'd6, 8'h01);

        // R11 timer trigger together with pointer write
        wr(3'd2, 8'h03);
        @(negedge clk);
        host_we = 1'b1; host_off = 3'd6; host_wdata = 8'h03; timer_tick = 1'b1;
        @(negedge clk);
        host_we = 1'b0; timer_tick = 1'b0;
        chk("R11 old entry", {conv_start, gain, chan}, {1'b1, 8'h21});
        tick1();
        chk("R11 host pointer wins", {conv_start, gain, chan}, {1'b1, 8'h43});
        tick1();
        chk("R4 wrap", {gain, chan}, 8'h10);

        // R7 three consecutive ticks give three strobes
        @(negedge clk);
        timer_tick = 1'b1;
        repeat (3) @(negedge clk);
        timer_tick = 1'b0;
        chk("R7 last of burst", {conv_start, gain, chan}, {1'b1, 8'h43});
        count_starts(3, cnt);
        chk("R7 burst ends", cnt, 0);

        // R6 ignored in timer mode (pointer now 0)
        ext_pacer = 1'b1;
        count_starts(6, cnt);
        chk("R6 pin ignored", cnt, 0);
        ext_pacer = 1'b0;
        repeat (4) @(negedge clk);

        // R8 busy trigger
        conv_busy = 1'b1;
        tick1();
        chk("R8 no strobe", conv_start, 0);
        chk("R8 overrun set", overrun, 1);
        conv_busy = 1'b0;
        tick1();
        chk("R8 pointer held", {conv_start, gain, chan}, {1'b1, 8'h10});
        chk("R8 overrun sticky", overrun, 1);

        // R5 software start ignored in external mode; R7 tick ignored too
        wr(3'd2, 8'h02);
        wr(3'd0, 8'h00);
        chk("R5 sw ignored", conv_start, 0);
        tick1();
        chk("R7 tick ignored", conv_start, 0);

        // R6 latency through synchronizer, pointer now 1
        @(negedge clk);
        ext_pacer = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 not early", conv_start, 0);
        @(negedge clk);
        chk("R6 edge strobe", {conv_start, gain, chan}, {1'b1, 8'h21});
        count_starts(6, cnt);
        chk("R6 held high", cnt, 0);
        ext_pacer = 1'b0;
        repeat (3) @(negedge clk);
        ext_pacer = 1'b1;
        count_starts(6, cnt);
        chk("R6 second edge", cnt, 1);
        chk("R6 second entry", {gain, chan}, 8'h32);
        ext_pacer = 1'b0;

        // R9 arm clears overrun and resets pointer
        wr(3'd4, 8'h03);
        chk("R9 overrun cleared", overrun, 0);
        wr(3'd2, 8'h01);
        wr(3'd0, 8'h00);
        chk("R9 pointer zero", {conv_start, gain, chan}, {1'b1, 8'h10});

        // R10 parity violation
        wr(3'd6, 8'h00);
        wr(3'd7, 8'h05);
        wr(3'd4, 8'h01);
        repeat (5) @(negedge clk);
        chk("R10 parity error", rule_err, 1);
        wr(3'd6, 8'h00);
        wr(3'd7, 8'h04);
        wr(3'd4, 8'h01);
        repeat (5) @(negedge clk);
        chk("R10 good pair", rule_err, 0);
        wr(3'd4, 8'h02);
        repeat (6) @(negedge clk);
        chk("R10 odd count", rule_err, 1);

        // R4 R10 single entry with odd channel at address 0
        wr(3'd6, 8'h00);
        wr(3'd7, 8'h05);
        wr(3'd4, 8'h00);
        repeat (4) @(negedge clk);
        chk("R10 single exempt", rule_err, 0);
        wr(3'd0, 8'h00);
        chk("R4 single first", {conv_start, gain, chan}, {1'b1, 8'h05});
        wr(3'd0, 8'h00);
        chk("R4 single repeat", {conv_start, gain, chan}, {1'b1, 8'h05});

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule